// File: doc/BRIEF.md
# Stop Recovery and Watchdog Prescaler Counter

This block is a free-running binary counter that advances on the falling edge of the reference clock. It has three jobs. After power-on it delays the enable for the internal bus clocks until the oscillator has had a full counter period to settle. When the part leaves stop mode it times the recovery delay again. At all other times it acts as a prescaler, and each time it wraps it sends a one-cycle tick to the watchdog.

The stop-entry strobe clears the counter and drops the bus clock enable. The counter then stays at zero until a wake request arrives. On the wake edge the short-recovery bit is sampled. That bit selects either the short delay or the full counter period before the bus clock enable goes high again.

Top module: `stop_rec_prescaler`

## Requirements
- R1: While `por_rst` is high, `bus_clk_en` and `wdog_tick` are both 0.
- R2: After `por_rst` is released, `bus_clk_en` goes high on exactly the 4096th falling edge of `clk_ref`.
- R3: A falling edge that samples `stop_req` high leaves `bus_clk_en` at 0 and `wdog_tick` at 0, and clears the counter.
- R4: While stopped with no wake request, the counter holds at zero and no tick is produced. The recovery delay that follows is therefore independent of how long the block was stopped.
- R5: A wake request sampled with `short_rec` = 1 raises `bus_clk_en` on the 32nd falling edge after the wake edge.
- R6: A wake request sampled with `short_rec` = 0 raises `bus_clk_en` on the 4096th falling edge after the wake edge.
- R7: `short_rec` is sampled only on the wake edge. Changes to it afterwards do not alter the recovery delay in progress.
- R8: `wdog_tick` is a one-cycle pulse, issued on the edge where the counter wraps from 4095 to 0. While running it therefore recurs every 4096 falling edges.
- R9: Once high, `bus_clk_en` stays high until the next stop strobe. A `wake_req` while not stopped has no effect on the enable or on the tick period.
- R10: `stop_req` takes priority over `wake_req` on the same edge. A stop during recovery restarts the whole sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock; all state changes on its falling edge |
| por_rst | input | 1 | Power-on reset, asynchronous, active high |
| stop_req | input | 1 | Stop-entry strobe |
| wake_req | input | 1 | Wake request from an interrupt or reset |
| short_rec | input | 1 | Selects the short recovery delay when 1 |
| bus_clk_en | output | 1 | Enable for the internal bus clocks |
| wdog_tick | output | 1 | One-cycle pulse to the watchdog on each counter wrap |

## Verification
The bench builds the block with its defaults: a 12-bit counter and a 32-cycle short delay. With those values the full 4096-cycle recovery, the power-on delay and the exact tick period can all be measured edge by edge within a short run. A vector table walks stop and wake sequences with different idle lengths and `short_rec` changes after the wake edge. Directed tests cover the power-on delay, how the tick lines up with the wrap, stop colliding with wake, and stray wake requests while running.

// File: rtl/stop_rec_prescaler.sv
module stop_rec_prescaler #(
  parameter int CNT_W        = 12,
  parameter int SHORT_CYCLES = 32
) (
  input  logic clk_ref,
  input  logic por_rst,
  input  logic stop_req,
  input  logic wake_req,
  input  logic short_rec,
  output logic bus_clk_en,
  output logic wdog_tick
);

  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_CYCLES - 1);
  localparam logic [CNT_W-1:0] FULL_LAST  = '1;

  logic [CNT_W-1:0] cnt;
  logic             stopped;
  logic             waiting;
  logic             use_short;
  logic             en_q;
  logic             tick_q;

  logic [CNT_W-1:0] last;
  logic             wrap;
  logic             done;

  assign last = use_short ? SHORT_LAST : FULL_LAST;
  assign wrap = (cnt == FULL_LAST);
  assign done = waiting && (cnt == last);

  always_ff @(negedge clk_ref or posedge por_rst) begin
    if (por_rst) begin
      cnt       <= '0;
      stopped   <= 1'b0;
      waiting   <= 1'b1;
      use_short <= 1'b0;
      en_q      <= 1'b0;
      tick_q    <= 1'b0;
    end else if (stop_req) begin
      cnt     <= '0;
      stopped <= 1'b1;
      waiting <= 1'b0;
      en_q    <= 1'b0;
      tick_q  <= 1'b0;
    end else if (stopped) begin
      tick_q <= 1'b0;
      if (wake_req) begin
        stopped   <= 1'b0;
        waiting   <= 1'b1;
        use_short <= short_rec;
      end
    end else begin
      cnt    <= cnt + 1'b1;
      tick_q <= wrap;
      if (done) begin
        waiting <= 1'b0;
        en_q    <= 1'b1;
      end
    end
  end

  assign bus_clk_en = en_q;
  assign wdog_tick  = tick_q;

endmodule

module stop_rec_prescaler_chk (
  input logic clk_ref,
  input logic por_rst,
  input logic stop_req,
  input logic wake_req,
  input logic bus_clk_en,
  input logic wdog_tick
);

  p_tick_single_r8: assert property (@(negedge clk_ref) disable iff (por_rst)
    wdog_tick |=> !wdog_tick);

  p_stop_drops_en_r3: assert property (@(negedge clk_ref) disable iff (por_rst)
    stop_req |=> (!bus_clk_en && !wdog_tick));

  p_en_sticky_r9: assert property (@(negedge clk_ref) disable iff (por_rst)
    (bus_clk_en && !stop_req) |=> bus_clk_en);

  p_stop_wins_r10: assert property (@(negedge clk_ref) disable iff (por_rst)
    (stop_req && wake_req) |=> !bus_clk_en);

  p_rise_no_stop_r3: assert property (@(negedge clk_ref) disable iff (por_rst)
    $rose(bus_clk_en) |-> !$past(stop_req));

  always_comb begin
    if (por_rst) begin
      a_reset_quiet_r1: assert (!bus_clk_en && !wdog_tick);
    end
  end

endmodule

bind stop_rec_prescaler stop_rec_prescaler_chk u_chk (
  .clk_ref   (clk_ref),
  .por_rst   (por_rst),
  .stop_req  (stop_req),
  .wake_req  (wake_req),
  .bus_clk_en(bus_clk_en),
  .wdog_tick (wdog_tick)
);

// File: tb/stop_rec_prescaler_tb.sv
module stop_rec_prescaler_tb_top;

  logic clk_ref = 1'b0;
  logic por_rst = 1'b1;
  logic stop_req = 1'b0;
  logic wake_req = 1'b0;
  logic short_rec = 1'b0;
  logic bus_clk_en;
  logic wdog_tick;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk_ref = ~clk_ref;

  stop_rec_prescaler dut_i (
    .clk_ref   (clk_ref),
    .por_rst   (por_rst),
    .stop_req  (stop_req),
    .wake_req  (wake_req),
    .short_rec (short_rec),
    .bus_clk_en(bus_clk_en),
    .wdog_tick (wdog_tick)
  );

  // columns: short_rec at wake, short_rec after wake, idle cycles stopped, expected delay
  localparam int NV = 6;
  localparam int VEC [NV][4] = '{
    '{1, 1,   0,   32},
    '{1, 0,   5,   32},
    '{0, 0,   3, 4096},
    '{1, 1, 100,   32},
    '{0, 1,   0, 4096},
    '{1, 0,  17,   32}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_stop(input logic with_wake);
    @(posedge clk_ref);
    stop_req = 1'b1;
    wake_req = with_wake;
    @(posedge clk_ref);
    stop_req = 1'b0;
    wake_req = 1'b0;
  endtask

  task automatic do_wake(input logic s);
    @(posedge clk_ref);
    wake_req  = 1'b1;
    short_rec = s;
    @(posedge clk_ref);
    wake_req = 1'b0;
  endtask

  task automatic measure_en(output int n, input int after_short);
    n = 0;
    short_rec = after_short[0];
    forever begin
      #1;
      if (bus_clk_en || n > 9000) break;
      n++;
      @(posedge clk_ref);
    end
  endtask

  task automatic tick_period(output int n);
    n = 0;
    forever begin
      @(posedge clk_ref);
      #1;
      n++;
      if (wdog_tick || n > 9000) break;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk_ref);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int n;
    int ticks;
    repeat (3) @(posedge clk_ref);
    #1;
    check("R1 en in reset", int'(bus_clk_en), 0);
    check("R1 tick in reset", int'(wdog_tick), 0);

    @(posedge clk_ref);
    por_rst = 1'b0;
    measure_en(n, 0);
    check("R2 power-on delay", n, 4096);
    check("R8 tick on first wrap", int'(wdog_tick), 1);
    @(posedge clk_ref); #1;
    check("R8 tick single cycle", int'(wdog_tick), 0);
    tick_period(n);
    check("R8 tick period", n, 4095);

    for (int i = 0; i < NV; i++) begin
      do_stop(1'b0);
      #1;
      check("R3 en low after stop", int'(bus_clk_en), 0);
      ticks = 0;
      for (int k = 0; k < VEC[i][2]; k++) begin
        @(posedge clk_ref); #1;
        if (wdog_tick || bus_clk_en) ticks++;
      end
      check("R4 quiet while stopped", ticks, 0);
      do_wake(VEC[i][0][0]);
      measure_en(n, VEC[i][1]);
      if (VEC[i][0] == 1) check("R5 R7 short recovery", n, VEC[i][3]);
      else                check("R6 R7 full recovery", n, VEC[i][3]);
    end

    tick_period(n);
    for (int k = 0; k < 4; k++) begin
      @(posedge clk_ref);
      wake_req = 1'b1;
      @(posedge clk_ref);
      wake_req = 1'b0;
      #1;
      check("R9 en held despite wake", int'(bus_clk_en), 1);
    end
    tick_period(n);
    check("R9 tick period after stray wake", n, 4096 - 8);
    tick_period(n);
    check("R8 tick period steady", n, 4096);

    do_stop(1'b0);
    do_wake(1'b0);
    repeat (100) @(posedge clk_ref);
    do_stop(1'b1);
    #1;
    check("R10 stop beats wake", int'(bus_clk_en), 0);
    ticks = 0;
    for (int k = 0; k < 50; k++) begin
      @(posedge clk_ref); #1;
      if (bus_clk_en) ticks++;
    end
    check("R10 stays stopped", ticks, 0);
    do_wake(1'b1);
    measure_en(n, 1);
    check("R10 restart after stop", n, 32);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule